// File: doc/BRIEF.md
# Seconds Counter Peripheral with Match Alarm

This block is a register-mapped real-time clock. A 32-bit seconds count advances by one on every clock cycle in which an external one-second enable is high. It wraps from all ones to zero. Software can overwrite the count at any time. It can also program a match value. When the count equals the match value, a sticky raw status bit sets. That bit is gated by a one-bit mask and drives a level interrupt.

The match compare runs on every tick. It also runs in the same cycle as any write to the load or match register, so a write that creates equality raises the status without waiting for the next second. The register port is a simple APB-style bus with a setup phase and an enable phase, and no wait states. Read data is combinational from the address. A write takes effect at the clock edge of its enable phase. Only word-aligned offsets inside the low 4 KiB page decode. A read-only word of identification bytes sits at the top of that page.

Top module: `sec_alarm_rtc`

## Requirements
- R1: A synchronous active-low reset clears the count, match, load, mask and raw status to zero, and the interrupt output is low.
- R2: A write to offset 0x08 replaces the count with the written value. A read of 0x08 returns the last value written, and a read of 0x00 returns the current count.
- R3: The count rises by one on each edge where the tick enable is high, and it wraps from 0xFFFFFFFF to 0. A load write in the same cycle as a tick takes priority over the increment. Without a tick or a load, the count holds.
- R4: Raw status (offset 0x14, bit 0) sets when a tick brings the count equal to the match register (offset 0x04). This includes a match value reached only after the count wraps.
- R5: A write to the match or load register that makes the count and the match value equal sets raw status at that same write edge.
- R6: The mask register at 0x10 keeps only bit 0, and its other bits read as zero. The interrupt output and the masked status at 0x18 (bit 0) both equal raw AND mask.
- R7: Writing offset 0x1C with bit 0 set clears raw status, and writing it with bit 0 clear leaves raw status unchanged. Raw status otherwise stays set. If a match and a clear fall in the same cycle, raw status ends set.
- R8: Offset 0x0C always reads 1, and writes to it change nothing.
- R9: Reads of 0xFE0 through 0xFFC return one identification byte per word: 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, in rising address order.
- R10: Reads of 0x1C and of unmapped offsets return zero. Writes to 0x00, 0x14, 0x18 or unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-second advance enable, one cycle per second |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus enable (access phase) |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access |
| irq | output | 1 | Level interrupt, raw status AND mask |

## Verification
Two kinds of event can land on the same edge. A tick can coincide with a bus write to the load register, and a tick that produces a match can coincide with a clear write. The bench provokes both by raising the tick enable during the enable phase of the write. It then judges the load case by reading back the loaded value rather than value+1. It judges the clear case by reading raw status as still set and seeing the interrupt stay high.

// File: rtl/rtcx_pkg.sv
package rtcx_pkg;
   // word indices (byte offset >> 2) of the register page
   localparam int unsigned WI_COUNT = 0;
   localparam int unsigned WI_MATCH = 1;
   localparam int unsigned WI_LOAD  = 2;
   localparam int unsigned WI_CTRL  = 3;
   localparam int unsigned WI_MASK  = 4;
   localparam int unsigned WI_RAW   = 5;
   localparam int unsigned WI_MSKD  = 6;
   localparam int unsigned WI_CLR   = 7;
   // upper seven bits of the word index that select the ID block
   localparam logic [6:0] ID_BLOCK = 7'h7F;

   function automatic logic [7:0] id_byte(input logic [2:0] idx);
      case (idx)
         3'd0: id_byte = 8'h31;
         3'd1: id_byte = 8'h10;
         3'd2: id_byte = 8'h14;
         3'd3: id_byte = 8'h00;
         3'd4: id_byte = 8'h0D;
         3'd5: id_byte = 8'hF0;
         3'd6: id_byte = 8'h05;
         default: id_byte = 8'hB1;
      endcase
   endfunction
endpackage

// File: rtl/rtcx_counter.sv
module rtcx_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load_en,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count_q,
   output logic [CNT_W-1:0] count_nxt,
   output logic [CNT_W-1:0] load_q
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   // load has priority; the increment wraps naturally at CNT_W bits
   always_comb begin
      if (load_en)   count_nxt = load_val;
      else if (tick) count_nxt = count_q + ONE;
      else           count_nxt = count_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
         load_q  <= '0;
      end else begin
         count_q <= count_nxt;
         if (load_en) load_q <= load_val;
      end
   end

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> (count_q == $past(load_val) && load_q == $past(load_val))); // R2
   AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load_en) |=> count_q == $past(count_q) + ONE); // R3
   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load_en) |=> $stable(count_q)); // R3
endmodule

// File: rtl/rtcx_alarm.sv
module rtcx_alarm #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             eval_en,
   input  logic             match_wr,
   input  logic             mask_wr,
   input  logic             clr_wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic [CNT_W-1:0] count_nxt,
   output logic [CNT_W-1:0] match_q,
   output logic             mask_q,
   output logic             raw_q
);
   logic [CNT_W-1:0] match_nxt;
   logic             hit;

   assign match_nxt = match_wr ? wdata : match_q;
   // compare the values the registers will hold after this edge
   assign hit = (eval_en || match_wr) && (count_nxt == match_nxt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         match_q <= '0;
         mask_q  <= 1'b0;
         raw_q   <= 1'b0;
      end else begin
         match_q <= match_nxt;
         if (mask_wr) mask_q <= wdata[0];
         if (hit)                      raw_q <= 1'b1;
         else if (clr_wr && wdata[0])  raw_q <= 1'b0;
      end
   end

   AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_q && !(clr_wr && wdata[0])) |=> raw_q); // R7
   AST_RAW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && wdata[0] && !eval_en && !match_wr) |=> !raw_q); // R7
   AST_MATCH_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      (match_wr && wdata == count_nxt) |=> raw_q); // R5
endmodule

// File: rtl/rtcx_readmux.sv
module rtcx_readmux
   import rtcx_pkg::*;
#(
   parameter int  DATA_W = 32,
   parameter int  CNT_W  = 32,
   parameter bit  ID_EN  = 1'b1
) (
   input  logic              in_page,
   input  logic [9:0]        widx,
   input  logic [CNT_W-1:0]  count_q,
   input  logic [CNT_W-1:0]  match_q,
   input  logic [CNT_W-1:0]  load_q,
   input  logic              mask_q,
   input  logic              raw_q,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] id_word;

   generate
      if (ID_EN) begin : g_id
         assign id_word = (widx[9:3] == ID_BLOCK) ? DATA_W'(id_byte(widx[2:0])) : '0;
      end else begin : g_no_id
         assign id_word = '0;
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (in_page) begin
         case (widx)
            10'(WI_COUNT): rdata = DATA_W'(count_q);
            10'(WI_MATCH): rdata = DATA_W'(match_q);
            10'(WI_LOAD):  rdata = DATA_W'(load_q);
            10'(WI_CTRL):  rdata = DATA_W'(1);
            10'(WI_MASK):  rdata = DATA_W'(mask_q);
            10'(WI_RAW):   rdata = DATA_W'(raw_q);
            10'(WI_MSKD):  rdata = DATA_W'(raw_q & mask_q);
            10'(WI_CLR):   rdata = '0;
            default:       rdata = id_word;
         endcase
      end
   end
endmodule

// File: rtl/sec_alarm_rtc.sv
module sec_alarm_rtc
   import rtcx_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32,
   parameter bit ID_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   output logic              irq
);
   generate
      if (ADDR_W < 12 || ADDR_W > 32) begin : g_bad_addr
         $error("ADDR_W must lie in 12..32");
      end
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W must lie in 1..DATA_W");
      end
   endgenerate

   logic [31:0]      a32;
   logic             in_page;
   logic [9:0]       widx;
   logic             wr;
   logic             wr_load, wr_match, wr_mask, wr_clr;
   logic [CNT_W-1:0] count_q, count_nxt, load_q, match_q;
   logic             mask_q, raw_q;

   assign a32     = 32'(paddr);
   assign in_page = (a32[31:12] == 20'd0) && (a32[1:0] == 2'd0);
   assign widx    = a32[11:2];
   assign wr      = psel && penable && pwrite && in_page;

   assign wr_load  = wr && (widx == 10'(WI_LOAD));
   assign wr_match = wr && (widx == 10'(WI_MATCH));
   assign wr_mask  = wr && (widx == 10'(WI_MASK));
   assign wr_clr   = wr && (widx == 10'(WI_CLR));

   rtcx_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(sec_tick), .load_en(wr_load),
      .load_val(pwdata[CNT_W-1:0]), .count_q(count_q), .count_nxt(count_nxt),
      .load_q(load_q)
   );

   rtcx_alarm #(.CNT_W(CNT_W)) u_alm (
      .clk(clk), .rst_n(rst_n), .eval_en(sec_tick || wr_load),
      .match_wr(wr_match), .mask_wr(wr_mask), .clr_wr(wr_clr),
      .wdata(pwdata[CNT_W-1:0]), .count_nxt(count_nxt),
      .match_q(match_q), .mask_q(mask_q), .raw_q(raw_q)
   );

   rtcx_readmux #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ID_EN(ID_EN)) u_rd (
      .in_page(in_page), .widx(widx), .count_q(count_q), .match_q(match_q),
      .load_q(load_q), .mask_q(mask_q), .raw_q(raw_q), .rdata(prdata)
   );

   assign irq = raw_q & mask_q;

   AST_LOAD_MATCH_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_load && pwdata[CNT_W-1:0] == match_q && !wr_match) |=> raw_q); // R5
   AST_TICK_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && !wr && count_q + CNT_W'(1) == match_q) |=> raw_q); // R4
   AST_CTRL_CONST: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && in_page && widx == 10'(WI_CTRL)) |-> prdata == DATA_W'(1)); // R8
endmodule

// File: tb/tb_sec_alarm_rtc.sv
`timescale 1ns/100ps
module tb_sec_alarm_rtc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sec_tick = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   typedef struct {
      logic [11:0] addr;
      logic [31:0] exp;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   sec_alarm_rtc dut (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .psel(psel),
      .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
      .prdata(prdata), .irq(irq)
   );

   // monitor: compare read data in the middle of each access phase
   always @(negedge clk) begin
      if (psel && penable && !pwrite) begin
         exp_t e;
         checks++;
         if (sb.size() == 0) begin
            failures++;
            $display("FAIL scoreboard: read at %h with no expected item", paddr);
         end else begin
            e = sb.pop_front();
            if (prdata !== e.exp || paddr !== e.addr) begin
               failures++;
               $display("FAIL %s: addr %h actual %h expected %h", e.tag, paddr, prdata, e.exp);
            end
         end
      end
   end

   task automatic bus(input logic w, input logic [11:0] a, input logic [31:0] d, input logic tk);
      @(posedge clk); #1 psel = 1'b1; penable = 1'b0; pwrite = w; paddr = a; pwdata = d;
      @(posedge clk); #1 penable = 1'b1; sec_tick = tk;
      @(posedge clk); #1 psel = 1'b0; penable = 1'b0; pwrite = 1'b0; sec_tick = 1'b0;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      bus(1'b1, a, d, 1'b0);
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
      exp_t e;
      e.addr = a; e.exp = exp; e.tag = tag;
      sb.push_back(e);
      bus(1'b0, a, 32'd0, 1'b0);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1 sec_tick = 1'b1;
         @(posedge clk); #1 sec_tick = 1'b0;
      end
   endtask

   task automatic chk_irq(input logic exp, input string tag);
      checks++;
      if (irq !== exp) begin
         failures++;
         $display("FAIL %s: irq actual %b expected %b", tag, irq, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         if (sb.size() != 0) begin
            failures++;
            $display("FAIL scoreboard: %0d reads never observed", sb.size());
         end
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(12'h000, 32'd0, "R1 count");
      rd(12'h004, 32'd0, "R1 match");
      rd(12'h008, 32'd0, "R1 load");
      rd(12'h010, 32'd0, "R1 mask");
      rd(12'h014, 32'd0, "R1 raw");
      chk_irq(1'b0, "R1 irq");

      // R2 load and read back
      wr(12'h008, 32'd100);
      rd(12'h000, 32'd100, "R2 count after load");
      rd(12'h008, 32'd100, "R2 load readback");

      // R3 ticks, hold, load priority over tick
      ticks(3);
      rd(12'h000, 32'd103, "R3 three ticks");
      rd(12'h000, 32'd103, "R3 hold without tick");
      bus(1'b1, 12'h008, 32'd500, 1'b1);
      rd(12'h000, 32'd500, "R3 load wins over tick");

      // R4 tick match, R6 mask gating
      wr(12'h004, 32'd505);
      rd(12'h014, 32'd0, "R4 no match yet");
      ticks(5);
      rd(12'h014, 32'd1, "R4 raw after tick match");
      rd(12'h018, 32'd0, "R6 masked status with mask off");
      chk_irq(1'b0, "R6 irq masked off");
      wr(12'h010, 32'hFFFF_FFFF);
      rd(12'h010, 32'd1, "R6 only bit 0 stored");
      rd(12'h018, 32'd1, "R6 masked status with mask on");
      chk_irq(1'b1, "R6 irq with mask on");

      // R7 sticky and clear
      wr(12'h01C, 32'hFFFF_FFFE);
      rd(12'h014, 32'd1, "R7 clear without bit 0 keeps raw");
      ticks(2);
      rd(12'h014, 32'd1, "R7 raw sticky over ticks");
      wr(12'h01C, 32'd1);
      rd(12'h014, 32'd0, "R7 cleared");
      chk_irq(1'b0, "R7 irq after clear");

      // R3/R4 wrap
      wr(12'h008, 32'hFFFF_FFFE);
      wr(12'h004, 32'd1);
      ticks(2);
      rd(12'h000, 32'd0, "R3 wrap to zero");
      rd(12'h014, 32'd0, "R4 no match before wrap target");
      ticks(1);
      rd(12'h014, 32'd1, "R4 match after wrap");
      chk_irq(1'b1, "R4 irq after wrap match");
      wr(12'h01C, 32'd1);

      // R5 immediate set on match write and on load write
      wr(12'h004, 32'd1);
      rd(12'h014, 32'd1, "R5 match write equal to count");
      wr(12'h01C, 32'd1);
      wr(12'h008, 32'd50);
      wr(12'h004, 32'd60);
      rd(12'h014, 32'd0, "R5 no match at 50");
      wr(12'h008, 32'd60);
      rd(12'h014, 32'd1, "R5 load write equal to match");

      // R7 set wins over clear in the same cycle
      wr(12'h004, 32'd61);
      bus(1'b1, 12'h01C, 32'd1, 1'b1);
      rd(12'h014, 32'd1, "R7 match beats clear");
      chk_irq(1'b1, "R7 irq kept by match");
      wr(12'h01C, 32'd1);
      rd(12'h014, 32'd0, "R7 clear after collision");

      // R8 control
      rd(12'h00C, 32'd1, "R8 control reads one");
      wr(12'h00C, 32'd0);
      rd(12'h00C, 32'd1, "R8 control write ignored");

      // R9 identification bytes
      begin
         logic [7:0] idv [8] = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
         for (int i = 0; i < 8; i++)
            rd(12'hFE0 + 12'(i * 4), 32'(idv[i]), "R9 id byte");
      end

      // R10 write-only and unmapped reads, ignored writes
      rd(12'h01C, 32'd0, "R10 clear register reads zero");
      rd(12'h020, 32'd0, "R10 unmapped 0x20");
      rd(12'h800, 32'd0, "R10 unmapped 0x800");
      rd(12'hFDC, 32'd0, "R10 unmapped below id");
      wr(12'h000, 32'd777);
      wr(12'h014, 32'd1);
      wr(12'h018, 32'd1);
      wr(12'h024, 32'd5);
      rd(12'h000, 32'd61, "R10 count unchanged");
      rd(12'h004, 32'd61, "R10 match unchanged");
      rd(12'h008, 32'd60, "R10 load unchanged");
      rd(12'h014, 32'd0, "R10 raw unchanged");
      rd(12'h010, 32'd1, "R10 mask unchanged");

      // R1 reset again from a busy state
      @(posedge clk); #1 rst_n = 1'b0;
      @(posedge clk); #1 rst_n = 1'b1;
      rd(12'h000, 32'd0, "R1 count after second reset");
      rd(12'h010, 32'd0, "R1 mask after second reset");

      repeat (3) @(posedge clk);
      finish_run();
   end
endmodule